// File: doc/BRIEF.md
# Dual-Strobe Burst Address Sequencer

This block is the command and address front end of a synchronous burst memory. On each clock edge it looks at two active-low address strobes, one intended for a processor and one for a memory controller. It also looks at three chip selects and decides among three outcomes: load a new 18-bit start address, deselect the device, or continue the burst that is already open. Once a burst is open, an active-low advance input steps a 2-bit beat counter. The array address is formed from the stored start address and that counter. A static order input chooses between an XOR-interleaved sequence and a modulo-4 linear sequence on the two low address bits.

The block also decodes a global write enable, a byte-write enable and four per-byte enables into a 4-bit byte write mask. It uses that mask to mark each access as a read or a write. Every result is registered. The outputs seen in the cycle after an edge therefore describe the access chosen at that edge: the array address, a read strobe, a write strobe with its byte mask, and a deselected flag. The storage array and the data pipeline sit outside this block.

Top module: `sbs_burst_seq`

## Requirements
- R1: When `strt_p_n` is low and all three chip selects are active (`cs0_n`=0, `cs1`=1, `cs2_n`=0), the next cycle shows `rd_stb`=1, `wr_stb`=0, `wr_mask`=0 and `arr_addr` equal to the `ext_addr` sampled on that edge, whatever the write enables are.
- R2: With `cs0_n` high, a low `strt_p_n` is ignored. If `strt_c_n` is also high, an open burst continues exactly as if no strobe were present.
- R3: `strt_c_n` low starts a cycle only when `strt_p_n` is high or blocked by `cs0_n`. The write enables on that edge choose the access: `wr_stb`=1 with the decoded mask if any byte is enabled, otherwise `rd_stb`=1.
- R4: On an edge with no strobe seen, `adv_n` low moves the beat counter one step. `adv_n` high holds `arr_addr` (suspend). A start edge always sets the beat to 0, whatever `adv_n` is.
- R5: With `order_ilv`=1, `arr_addr[1:0]` equals the start bits XOR the beat count, so start 01 gives 01,00,11,10. Bits 17:2 never change inside a burst.
- R6: With `order_ilv`=0, `arr_addr[1:0]` equals the start bits plus the beat count modulo 4, so start 10 gives 10,11,00,01.
- R7: The write mask has bit i for byte i. `gwr_n`=0 sets all four bits. Otherwise `bwr_n`=0 sets bit i where `byte_n[i]`=0. With no write enable active the access is a read.
- R8: The write enables are ignored on a `strt_p_n` start edge. On later continue edges they choose a write (with its mask) or a read at the current burst address.
- R9: A strobe seen while the chip is not selected sets `desel`=1 with both strobes low. The flag, and silence on `rd_stb` and `wr_stb`, last until the next load. Reset gives `desel`=1, no strobes and `arr_addr`=0.
- R10: When both strobes are low and `cs0_n` is low, the `strt_p_n` rules apply (a read start).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_addr | input | 18 | External start address |
| strt_p_n | input | 1 | Processor address strobe, active low |
| strt_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs0_n | input | 1 | Master chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Global write enable, active low |
| bwr_n | input | 1 | Byte write qualifier, active low |
| byte_n | input | 4 | Per-byte write enables, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| arr_addr | output | 18 | Array address of the current access |
| wr_mask | output | 4 | Byte write mask of the current access |
| rd_stb | output | 1 | Current access is a read |
| wr_stb | output | 1 | Current access is a write |
| desel | output | 1 | Device deselected |

## Verification
The hardest case to reach is a processor strobe that the master select blocks while a burst is open. It must be told apart from a load, so the stimulus first opens a burst at a known address. It then pulses `strt_p_n` with `cs0_n` high and `adv_n` low, and checks that the address advances instead of reloading. A second hard case is the tie between the two strobes, which is forced with write enables asserted so that a wrong winner shows up as a write. The burst-order cases wrap the beat counter past four beats in both orders.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        ACT_STEP  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_DESEL = 2'd2
    } sbs_act_e;
endpackage

// File: rtl/sbs_start_decode.sv
module sbs_start_decode
    import sbs_pkg::*;
(
    input  logic     strt_p_n,
    input  logic     strt_c_n,
    input  logic     cs0_n,
    input  logic     cs1,
    input  logic     cs2_n,
    output sbs_act_e act,
    output logic     by_proc
);
    logic p_seen;
    logic c_seen;
    logic sel;

    always_comb begin
        // the master select gates the processor strobe only
        p_seen  = !strt_p_n && !cs0_n;
        c_seen  = !strt_c_n && !p_seen;
        sel     = !cs0_n && cs1 && !cs2_n;
        by_proc = p_seen;
        if (p_seen || c_seen) begin
            act = sel ? ACT_LOAD : ACT_DESEL;
        end else begin
            act = ACT_STEP;
        end
    end
endmodule

// File: rtl/sbs_wmask_decode.sv
module sbs_wmask_decode #(
    parameter int BYTES = 4
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [BYTES-1:0] byte_n,
    output logic [BYTES-1:0] mask,
    output logic             any_wr
);
    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        assign mask[i] = !gwr_n || (!bwr_n && !byte_n[i]);
    end
    assign any_wr = |mask;
endmodule

// File: rtl/sbs_burst_order.sv
module sbs_burst_order #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ilv,
    output logic [ADDR_W-1:0] addr
);
    logic [BEAT_W-1:0] low;

    always_comb begin
        if (ilv) begin
            low = start[BEAT_W-1:0] ^ beat;
        end else begin
            low = start[BEAT_W-1:0] + beat;
        end
        addr = {start[ADDR_W-1:BEAT_W], low};
    end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BYTES  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strt_p_n,
    input  logic              strt_c_n,
    input  logic              adv_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [BYTES-1:0]  byte_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [BYTES-1:0]  wr_mask,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              desel
);
    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic              open;
        logic              desel;
        logic              rd;
        logic              wr;
        logic [BYTES-1:0]  mask;
    } seq_state_t;

    seq_state_t st_d, st_q;
    sbs_act_e   act;
    logic       by_proc;
    logic [BYTES-1:0] dec_mask;
    logic       dec_any;

    sbs_start_decode u_start (
        .strt_p_n (strt_p_n),
        .strt_c_n (strt_c_n),
        .cs0_n    (cs0_n),
        .cs1      (cs1),
        .cs2_n    (cs2_n),
        .act      (act),
        .by_proc  (by_proc)
    );

    sbs_wmask_decode #(.BYTES(BYTES)) u_wmask (
        .gwr_n  (gwr_n),
        .bwr_n  (bwr_n),
        .byte_n (byte_n),
        .mask   (dec_mask),
        .any_wr (dec_any)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rd   = 1'b0;
        st_d.wr   = 1'b0;
        st_d.mask = '0;
        case (act)
            ACT_LOAD: begin
                st_d.base  = ext_addr;
                st_d.beat  = '0;
                st_d.open  = 1'b1;
                st_d.desel = 1'b0;
                if (!by_proc && dec_any) begin
                    st_d.wr   = 1'b1;
                    st_d.mask = dec_mask;
                end else begin
                    st_d.rd = 1'b1;
                end
            end
            ACT_DESEL: begin
                st_d.open  = 1'b0;
                st_d.desel = 1'b1;
            end
            default: begin
                if (st_q.open) begin
                    if (!adv_n) begin
                        st_d.beat = st_q.beat + BEAT_ONE;
                    end
                    if (dec_any) begin
                        st_d.wr   = 1'b1;
                        st_d.mask = dec_mask;
                    end else begin
                        st_d.rd = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.desel <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    sbs_burst_order #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_order (
        .start (st_q.base),
        .beat  (st_q.beat),
        .ilv   (order_ilv),
        .addr  (arr_addr)
    );

    assign wr_mask = st_q.mask;
    assign rd_stb  = st_q.rd;
    assign wr_stb  = st_q.wr;
    assign desel   = st_q.desel;
endmodule

// File: rtl/sbs_burst_seq_chk.sv
module sbs_burst_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int BYTES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strt_p_n,
    input logic              strt_c_n,
    input logic              adv_n,
    input logic              cs0_n,
    input logic              cs1,
    input logic              cs2_n,
    input logic              gwr_n,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [BYTES-1:0]  wr_mask,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic              desel
);
    // R1 and R10: a selected processor strobe loads the address and starts a read
    p_proc_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strt_p_n && !cs0_n && cs1 && !cs2_n) |=>
            (rd_stb && !wr_stb && arr_addr == $past(ext_addr)));

    // R4: suspend holds the address when no strobe is present
    p_suspend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strt_p_n && strt_c_n && adv_n) |=> $stable(arr_addr));

    // R5: upper address bits never move inside a burst
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strt_p_n && strt_c_n) |=> $stable(arr_addr[ADDR_W-1:2]));

    // R7: a global write on a controller start writes every byte
    p_global_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strt_p_n && !strt_c_n && !cs0_n && cs1 && !cs2_n && !gwr_n) |=>
            (wr_stb && wr_mask == {BYTES{1'b1}}));

    // R9: a controller strobe without the master select deselects
    p_desel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && !strt_c_n) |=> (desel && !rd_stb && !wr_stb));

    // R9: a deselected device issues no access
    p_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        desel |-> (!rd_stb && !wr_stb && wr_mask == '0));

    // R3: read and write are never issued together
    p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));
endmodule

bind sbs_burst_seq sbs_burst_seq_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .strt_p_n (strt_p_n),
    .strt_c_n (strt_c_n),
    .adv_n    (adv_n),
    .cs0_n    (cs0_n),
    .cs1      (cs1),
    .cs2_n    (cs2_n),
    .gwr_n    (gwr_n),
    .arr_addr (arr_addr),
    .wr_mask  (wr_mask),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .desel    (desel)
);

// File: tb/tb_sbs_burst_seq.sv
module tb_sbs_burst_seq;
    localparam int AW = 18;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] ext_addr;
    logic          strt_p_n, strt_c_n, adv_n, cs0_n, cs1, cs2_n;
    logic          gwr_n, bwr_n, order_ilv;
    logic [NB-1:0] byte_n;
    logic [AW-1:0] arr_addr;
    logic [NB-1:0] wr_mask;
    logic          rd_stb, wr_stb, desel;

    always #5 clk = ~clk;

    sbs_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strt_p_n(strt_p_n), .strt_c_n(strt_c_n), .adv_n(adv_n),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .byte_n(byte_n), .order_ilv(order_ilv),
        .arr_addr(arr_addr), .wr_mask(wr_mask), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .desel(desel)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic          rd;
        logic          wr;
        logic [NB-1:0] mask;
        logic          dsl;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference state kept from the requirements
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    bit            m_open = 1'b0;
    bit            m_dsl  = 1'b1;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = order_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic idle_inputs();
        strt_p_n = 1'b1; strt_c_n = 1'b1; adv_n = 1'b1;
        cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        gwr_n = 1'b1; bwr_n = 1'b1; byte_n = '1;
    endtask

    // inputs are set by the caller before calling; this models the edge
    task automatic drive(input string tag);
        exp_t e;
        bit p_seen, c_seen, sel;
        logic [NB-1:0] msk;
        for (int i = 0; i < NB; i++) msk[i] = !gwr_n || (!bwr_n && !byte_n[i]);
        p_seen = !strt_p_n && !cs0_n;
        c_seen = !strt_c_n && !p_seen;
        sel    = !cs0_n && cs1 && !cs2_n;
        e.rd = 1'b0; e.wr = 1'b0; e.mask = '0; e.tag = tag;
        if (p_seen || c_seen) begin
            if (sel) begin
                m_base = ext_addr; m_beat = 2'd0; m_open = 1'b1; m_dsl = 1'b0;
                if (c_seen && (msk != 0)) begin e.wr = 1'b1; e.mask = msk; end
                else e.rd = 1'b1;
            end else begin
                m_open = 1'b0; m_dsl = 1'b1;
            end
        end else if (m_open) begin
            if (!adv_n) m_beat = m_beat + 2'd1;
            if (msk != 0) begin e.wr = 1'b1; e.mask = msk; end
            else e.rd = 1'b1;
        end
        e.addr = m_addr();
        e.dsl  = m_dsl;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (arr_addr !== e.addr || rd_stb !== e.rd || wr_stb !== e.wr ||
                wr_mask !== e.mask || desel !== e.dsl) begin
                errors++;
                $display("FAIL %s: got addr=%h rd=%b wr=%b mask=%b desel=%b exp addr=%h rd=%b wr=%b mask=%b desel=%b",
                         e.tag, arr_addr, rd_stb, wr_stb, wr_mask, desel,
                         e.addr, e.rd, e.wr, e.mask, e.dsl);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got cycles=%0d exp below 5000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; order_ilv = 1'b1; ext_addr = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (arr_addr !== '0 || rd_stb !== 1'b0 || wr_stb !== 1'b0 || desel !== 1'b1) begin
            errors++;
            $display("FAIL R9 reset: got addr=%h rd=%b wr=%b desel=%b exp addr=0 rd=0 wr=0 desel=1",
                     arr_addr, rd_stb, wr_stb, desel);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R8: processor start ignores the write enables
        ext_addr = 18'h12345; strt_p_n = 1'b0; gwr_n = 1'b0; bwr_n = 1'b0; byte_n = '0; adv_n = 1'b0;
        drive("R1 R8 proc start read");
        // R5: interleaved order from start 01, wrapping
        idle_inputs(); adv_n = 1'b0;
        drive("R5 ilv beat1");
        drive("R5 ilv beat2");
        drive("R5 ilv beat3");
        drive("R5 ilv wrap");
        // R4: suspend holds
        adv_n = 1'b1;
        drive("R4 suspend");
        drive("R4 suspend again");
        // R8: continue edge with byte write becomes a write
        bwr_n = 1'b0; byte_n = 4'b0110; adv_n = 1'b0;
        drive("R8 continue write");
        // R2: blocked processor strobe, burst continues
        idle_inputs(); cs0_n = 1'b1; strt_p_n = 1'b0; adv_n = 1'b0; ext_addr = 18'h3ffff;
        drive("R2 blocked proc strobe advances");

        // R6: linear order from start 10
        idle_inputs(); order_ilv = 1'b0; ext_addr = 18'h0a5a6; strt_p_n = 1'b0;
        drive("R6 lin start");
        idle_inputs(); adv_n = 1'b0;
        drive("R6 lin beat1");
        drive("R6 lin beat2");
        drive("R6 lin beat3");
        drive("R6 lin wrap");

        // R3 and R7: controller start, byte write mask
        idle_inputs(); order_ilv = 1'b1; ext_addr = 18'h20003; strt_c_n = 1'b0;
        bwr_n = 1'b0; byte_n = 4'b1010;
        drive("R3 R7 ctrl start byte write");
        idle_inputs(); adv_n = 1'b0; bwr_n = 1'b0; byte_n = 4'b1110;
        drive("R7 continue byte0");
        // R7: global write overrides byte enables
        gwr_n = 1'b0; bwr_n = 1'b1; byte_n = '1;
        drive("R7 global write");
        // R7: byte enables without qualifier read
        idle_inputs(); byte_n = '0;
        drive("R7 no qualifier read");
        // R3: controller start with no write enable reads
        idle_inputs(); ext_addr = 18'h00100; strt_c_n = 1'b0;
        drive("R3 ctrl start read");
        // R3: controller strobe loses to a selected processor strobe
        idle_inputs(); ext_addr = 18'h00200; strt_c_n = 1'b0; strt_p_n = 1'b0; gwr_n = 1'b0;
        drive("R10 both strobes proc wins");

        // R9: deselect by cs1 inactive on a processor strobe
        idle_inputs(); cs1 = 1'b0; strt_p_n = 1'b0; ext_addr = 18'h11111;
        drive("R9 desel by cs1");
        idle_inputs(); adv_n = 1'b0; gwr_n = 1'b0;
        drive("R9 desel persists");
        // R9: controller strobe with master select inactive
        idle_inputs(); ext_addr = 18'h00004; strt_p_n = 1'b0;
        drive("R1 reload");
        idle_inputs(); cs0_n = 1'b1; strt_c_n = 1'b0;
        drive("R9 ctrl strobe no master");
        idle_inputs();
        drive("R9 idle stays desel");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule